// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This block holds two independent 16-bit up-counters behind a small word-addressed register interface. Each channel divides the peripheral clock by a selectable power of two (8, 32, 128 or 512), counts on every divided tick, and compares its count against a programmable match value. When the two are equal on a tick, the counter returns to zero and keeps running. The channel can raise a single-clock interrupt pulse at that moment.

Software sets a channel's prescale and interrupt enable, and preloads its count and match value. It then runs or halts either channel through one shared start register. A halted channel keeps its count and discards any partial prescale period, so each start begins with a full divided period. Reads are combinational from the word address; writes take effect on the clock edge.

Top module: `dual_match_timer`

## Requirements
- R1: After reset the start register, both control registers and both counters read 0, and both match registers read 0xFFFF.
- R2: Word address a corresponds to byte offset 2a. Word 0 is the start register. Words 1, 2 and 3 are channel 0 control, count and match. Words 4, 5 and 6 are the same three for channel 1. Word 7 reads 0, and writes to it change no register.
- R3: Start register bit 0 runs channel 0 and bit 1 runs channel 1. Its other bits read 0.
- R4: A control register keeps only a 2-bit prescale select in bits 1:0 and an interrupt enable in bit 6. All other bits read 0.
- R5: Select values 0, 1, 2 and 3 divide the clock by 8, 32, 128 and 512. The first count after a start lands exactly one full divided period after the edge that wrote the start bit.
- R6: A halted channel holds its count, and its partial prescale period is discarded.
- R7: On a tick the counter goes to 0 if it equals the match value, and otherwise it increments. From 0xFFFF with no match it wraps to 0 without a match event.
- R8: A match event drives that channel's irq bit high for exactly one cycle, and only when the channel's interrupt enable is set.
- R9: A software write to a counter in the same cycle as a tick wins: the written value is stored and no match event occurs.
- R10: The two channels count and interrupt independently when both run with different settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a 16-bit word |
| addr | input | 3 | Word address (byte offset divided by 2) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the word at addr |
| irq | output | 2 | Per-channel single-cycle match pulse |

## Verification
The hardest case to reach is a counter write that arrives on the same edge as a prescaler tick. That edge is hidden inside the divider, and the ports show nothing of the divider's phase. The bench first halts the channel, which clears the divider. It then writes the start bit and counts edges from that write, so the counter write can be placed on the sixteenth edge after the start, which is the second tick at divide-by-8. A reference model that runs on every cycle checks each irq bit. Direct counts of cycles between pulses pin down every divide ratio.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned N_CH      = 2;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned BUS_W     = 16;
   localparam int unsigned ADDR_W    = 3;
   localparam int unsigned IE_BIT    = 6;
   // word address layout: start word, then a three-word block per channel
   localparam int unsigned W_START   = 0;
   localparam int unsigned CH_BASE   = 1;
   localparam int unsigned CH_STRIDE = 3;
   localparam int unsigned F_CTRL    = 0;
   localparam int unsigned F_CNT     = 1;
   localparam int unsigned F_CMP     = 2;

   function automatic logic [ADDR_W-1:0] word_of(input int unsigned ch, input int unsigned fld);
      return ADDR_W'(CH_BASE + CH_STRIDE * ch + fld);
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned PS_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

   logic [PS_W-1:0] pre_q;
   logic [PS_W:0]   limit;

   always_comb begin
      limit = ({{PS_W{1'b0}}, 1'b1} << (BASE_LOG2 + STEP_LOG2 * int'(sel))) - 1'b1;
      tick  = run && ({1'b0, pre_q} >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (!run)   pre_q <= '0;
      else if (tick)   pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
   end

   assert_divider_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ctrl_we,
   input  logic             cnt_we,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] wval,
   input  logic [SEL_W-1:0] sel_wval,
   input  logic             ie_wval,
   output logic [SEL_W-1:0] sel,
   output logic             ie,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp,
   output logic             irq
);
   logic tick;
   logic hit;

   tmr_prescale #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) i_prescale (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (sel),
      .tick (tick)
   );

   assign hit = tick && !cnt_we && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         ie  <= 1'b0;
         cnt <= '0;
         cmp <= '1;
         irq <= 1'b0;
      end else begin
         irq <= hit && ie;
         if (ctrl_we) begin
            sel <= sel_wval;
            ie  <= ie_wval;
         end
         if (cmp_we) cmp <= wval;
         if (cnt_we)      cnt <= wval;
         else if (tick)   cnt <= (cnt == cmp) ? '0 : cnt + 1'b1;
      end
   end

   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_match_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == '0));
   assert_hold_when_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_we) |=> $stable(cnt));
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt == $past(wval)));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [BUS_W-1:0]       wdata,
   output logic [BUS_W-1:0]       rdata,
   output logic [N_CH-1:0]        irq
);
   generate
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_width
         $error("CNT_W must lie between 2 and the bus width");
      end
      if (BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1) > 24) begin : g_bad_div
         $error("prescale range too wide");
      end
   endgenerate

   logic [N_CH-1:0]  run;
   logic [SEL_W-1:0] sel_a [N_CH];
   logic             ie_a  [N_CH];
   logic [CNT_W-1:0] cnt_a [N_CH];
   logic [CNT_W-1:0] cmp_a [N_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               run <= '0;
      else if (wr_en && addr == ADDR_W'(W_START)) run <= wdata[N_CH-1:0];
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) i_channel (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run[c]),
         .ctrl_we (wr_en && addr == word_of(c, F_CTRL)),
         .cnt_we  (wr_en && addr == word_of(c, F_CNT)),
         .cmp_we  (wr_en && addr == word_of(c, F_CMP)),
         .wval    (wdata[CNT_W-1:0]),
         .sel_wval(wdata[SEL_W-1:0]),
         .ie_wval (wdata[IE_BIT]),
         .sel     (sel_a[c]),
         .ie      (ie_a[c]),
         .cnt     (cnt_a[c]),
         .cmp     (cmp_a[c]),
         .irq     (irq[c])
      );
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(W_START)) rdata[N_CH-1:0] = run;
      for (int c = 0; c < N_CH; c++) begin
         if (addr == word_of(c, F_CTRL)) begin
            rdata[SEL_W-1:0] = sel_a[c];
            rdata[IE_BIT]    = ie_a[c];
         end
         if (addr == word_of(c, F_CNT)) rdata = BUS_W'(cnt_a[c]);
         if (addr == word_of(c, F_CMP)) rdata = BUS_W'(cmp_a[c]);
      end
   end

   assert_start_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(W_START)) |=> (run == $past(wdata[N_CH-1:0])));
endmodule

// File: tb/test_dual_match_timer.sv
module test_dual_match_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic [1:0]  irq;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dual_match_timer i_dual_match_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // behavioural reference model
   bit m_run[2];
   int m_sel[2];
   bit m_ie[2];
   int m_cnt[2];
   int m_cmp[2];
   int m_pre[2];
   bit m_irq[2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_run[c] = 0; m_sel[c] = 0; m_ie[c] = 0; m_cnt[c] = 0;
            m_cmp[c] = 'hFFFF; m_pre[c] = 0; m_irq[c] = 0;
         end
      end else begin
         bit tk[2];
         bit wc[2];
         for (int c = 0; c < 2; c++) begin
            int period;
            period = 8 * (4 ** m_sel[c]);
            tk[c] = m_run[c] && (m_pre[c] == period - 1);
            wc[c] = wr_en && (addr == 3'(2 + 3 * c));
         end
         for (int c = 0; c < 2; c++) begin
            m_irq[c] = tk[c] && !wc[c] && (m_cnt[c] == m_cmp[c]) && m_ie[c];
            if (!m_run[c] || tk[c]) m_pre[c] = 0;
            else m_pre[c] = m_pre[c] + 1;
            if (wc[c]) m_cnt[c] = int'(wdata);
            else if (tk[c]) m_cnt[c] = (m_cnt[c] == m_cmp[c]) ? 0 : (m_cnt[c] + 1) % 65536;
            if (wr_en && addr == 3'(1 + 3 * c)) begin
               m_sel[c] = int'(wdata[1:0]);
               m_ie[c]  = wdata[6];
            end
            if (wr_en && addr == 3'(3 + 3 * c)) m_cmp[c] = int'(wdata);
         end
         if (wr_en && addr == 3'd0) begin
            m_run[0] = wdata[0];
            m_run[1] = wdata[1];
         end
      end
   end

   function automatic int m_read(input int a);
      case (a)
         0: return (int'(m_run[1]) << 1) | int'(m_run[0]);
         1: return (int'(m_ie[0]) << 6) | m_sel[0];
         2: return m_cnt[0];
         3: return m_cmp[0];
         4: return (int'(m_ie[1]) << 6) | m_sel[1];
         5: return m_cnt[1];
         6: return m_cmp[1];
         default: return 0;
      endcase
   endfunction

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // irq compared against the model on every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         chk(int'(irq[0]), int'(m_irq[0]), "R8 irq0 per-cycle");
         chk(int'(irq[1]), int'(m_irq[1]), "R8 irq1 per-cycle");
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      addr = 3'(a);
      #1;
      v = int'(rdata);
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      int v;
      rd(a, v);
      chk(v, exp, tag);
      chk(v, m_read(a), {tag, " model"});
   endtask

   task automatic wait_irq(input int c, output int n);
      n = 0;
      while (irq[c] !== 1'b1 && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic measure_sel(input int s, input int exp);
      int n;
      wr(0, 0);
      wr(4, 16'h0040 | s);
      wr(5, 0);
      wr(6, 0);
      wr(0, 2);
      wait_irq(1, n);
      chk(n, exp, $sformatf("R5 select %0d first tick", s));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_chk(0, 0, "R1 start");
      rd_chk(1, 0, "R1 ctrl0");
      rd_chk(2, 0, "R1 cnt0");
      rd_chk(3, 'hFFFF, "R1 cmp0");
      rd_chk(4, 0, "R1 ctrl1");
      rd_chk(5, 0, "R1 cnt1");
      rd_chk(6, 'hFFFF, "R1 cmp1");
      rd_chk(7, 0, "R2 unmapped read");

      // R3 / R4 field masking
      wr(0, 'hFFFC);
      rd_chk(0, 0, "R3 upper start bits");
      wr(1, 'hFFFF);
      rd_chk(1, 'h0043, "R4 ctrl0 fields");
      wr(4, 'hFFBC);
      rd_chk(4, 0, "R4 ctrl1 masked bits");
      wr(1, 0);

      // R2 mapping of each word, unmapped write ignored
      wr(2, 'h1111); wr(3, 'h2222); wr(5, 'h3333); wr(6, 'h4444);
      wr(7, 'hFFFF);
      rd_chk(2, 'h1111, "R2 cnt0 word");
      rd_chk(3, 'h2222, "R2 cmp0 word");
      rd_chk(5, 'h3333, "R2 cnt1 word");
      rd_chk(6, 'h4444, "R2 cmp1 word");
      rd_chk(0, 0, "R2 unmapped write start");
      rd_chk(1, 0, "R2 unmapped write ctrl0");
      rd_chk(7, 0, "R2 unmapped write readback");

      // R5 / R7 channel 0: select 0, match 3
      begin
         int n;
         wr(1, 'h0040); wr(2, 0); wr(3, 3);
         wr(0, 1);
         wait_irq(0, n);
         chk(n, 32, "R5 select 0 first match");
         @(negedge clk);
         chk(int'(irq[0]), 0, "R8 pulse width");
         wait_irq(0, n);
         chk(n, 31, "R7 match period");
         rd_chk(2, 0, "R7 cleared after match");
      end

      // R6 hold while halted
      begin
         int v1, v2;
         repeat (13) @(negedge clk);
         wr(0, 0);
         rd(2, v1);
         repeat (100) @(negedge clk);
         rd(2, v2);
         chk(v2, v1, "R6 held count");
         chk(v1, m_cnt[0], "R6 held count model");
      end

      // R5 other selects on channel 1
      measure_sel(1, 32);
      measure_sel(2, 128);
      measure_sel(3, 512);

      // R6 partial prescale discarded across a halt
      begin
         int n;
         wr(0, 0); wr(4, 'h0041); wr(5, 0); wr(6, 0);
         wr(0, 2);
         repeat (20) @(negedge clk);
         wr(0, 0);
         wr(0, 2);
         wait_irq(1, n);
         chk(n, 32, "R6 full period after restart");
      end

      // R8 interrupt enable clear: no pulses
      begin
         int hits = 0;
         wr(0, 0); wr(4, 'h0000); wr(5, 0); wr(6, 0);
         wr(0, 2);
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq[1] === 1'b1) hits++;
         end
         chk(hits, 0, "R8 disabled interrupt");
      end

      // R9 counter write on a tick edge
      begin
         wr(0, 0); wr(1, 'h0040); wr(2, 0); wr(3, 1);
         wr(0, 1);
         repeat (14) @(negedge clk);
         wr(2, 1);
         chk(int'(irq[0]), 0, "R9 no match on write edge");
         rd_chk(2, 1, "R9 written value kept");
      end

      // R7 wrap without a match
      begin
         wr(0, 0); wr(2, 'hFFFE); wr(3, 5); wr(1, 'h0040);
         wr(0, 1);
         repeat (17) @(negedge clk);
         rd_chk(2, 0, "R7 wrap to zero");
         chk(int'(irq[0]), 0, "R7 wrap no pulse");
      end

      // R10 both channels, different settings
      begin
         int h0 = 0, h1 = 0;
         wr(0, 0);
         wr(1, 'h0040); wr(2, 0); wr(3, 2);
         wr(4, 'h0041); wr(5, 0); wr(6, 1);
         wr(0, 3);
         for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq[0] === 1'b1) h0++;
            if (irq[1] === 1'b1) h1++;
         end
         chk(h0, 16, "R10 channel 0 pulses");
         chk(h1, 6, "R10 channel 1 pulses");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule